// File: doc/BRIEF.md
# Sticky Event Flags with Three Clear Paths

This block keeps one sticky status flag per event source of a wheel-speed timer channel. The channel logic sends a one-clock pulse on a per-flag event input, and the matching flag rises on the next clock edge. It then stays high until one of three independent actions clears it. The first is a write-one-to-clear to the status register. The second is a bus read of the data register bound to that flag. The third is a DMA done acknowledge that answers the flag's DMA request.

A control register selects how pending flags are reported. With DMA mode off, the interrupt output is the OR of the set flags whose interrupt enable is set. With DMA mode on, each set flag holds its own DMA request line high until the flag is cleared. Any set event wins over every clear that hits the same flag in the same cycle.

Register map, in word addresses on `bus_addr`:
- Address 0 is the control register. Bit 0 is the DMA mode enable. Bit 1+i is the interrupt enable of flag i.
- Address 1 is the status register. Bit i is flag i.
- Address 2+i is the data register of flag i. It returns capture word i.

Top module: `efr_event_flags`

## Requirements
- R1: On synchronous reset, all flags, the DMA mode bit and all interrupt enables go to 0, and `irq` and `dma_req` are 0.
- R2: An `evt[i]` pulse sets flag i at the next clock edge. Further pulses while the flag is set leave it set.
- R3: Writing 1 to status bit i (address 1) clears flag i. Writing 0 to a status bit leaves that flag unchanged.
- R4: A read of address 2+i returns capture word i and clears flag i only. Reads of addresses 0 and 1 leave all flags unchanged.
- R5: Without a read strobe (`bus_rd` = 0), a data register address on the bus never clears a flag.
- R6: With control bit 0 set, `dma_done[i]` asserted while `dma_req[i]` is high clears flag i at the next edge.
- R7: With control bit 0 clear, `dma_done` has no effect on the flags and `dma_req` stays 0.
- R8: When a set pulse and any clear reach the same flag in the same cycle, the flag is set after that edge.
- R9: With control bit 0 clear, `irq` is 1 exactly when some flag i and its enable (control bit 1+i) are both set. With control bit 0 set, `irq` is 0.
- R10: With control bit 0 set, `dma_req[i]` equals flag i and stays high until flag i is cleared.
- R11: `bus_rdata` is registered. It carries the value of the register read in the cycle after the `bus_rd` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| evt | input | NUM_FLAGS | One-cycle event pulses, one per flag |
| cap_data | input | NUM_FLAGS*DATA_W | Capture words, word i at bits [i*DATA_W +: DATA_W] |
| dma_done | input | NUM_FLAGS | DMA done acknowledge per flag |
| dma_req | output | NUM_FLAGS | Registered DMA request per flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The following properties are checked on every cycle:
- A set pulse always leaves its flag high.
- A clear without a competing set drops the flag.
- Read-side clears happen only under a read strobe and hit at most one flag.
- In DMA mode, `irq` stays low and `dma_req` mirrors the flags.
- Outside DMA mode, `dma_req` stays low.
- An answered DMA done clears its flag.

Some behaviours can only be shown by the bench's scenarios:
- The status and control register bit layout.
- That a zero write leaves a flag untouched.
- That reads of other registers do not clear flags.
- The read-data latency and capture-word routing.
- That `dma_done` is ignored outside DMA mode.
- The enable-masked OR on `irq`.

// File: rtl/efr_pkg.sv
package efr_pkg;
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_STATUS = 1;
  localparam int unsigned REG_DATA0  = 2;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input int unsigned addr, input int unsigned nflags);
    if (addr == REG_CTRL)                                 return SEL_CTRL;
    else if (addr == REG_STATUS)                          return SEL_STATUS;
    else if (addr >= REG_DATA0 && addr < REG_DATA0+nflags) return SEL_DATA;
    else                                                  return SEL_NONE;
  endfunction
endpackage

// File: rtl/efr_addr_dec.sv
module efr_addr_dec
  import efr_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 3,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output reg_sel_e             sel_o,
  output logic [NUM_FLAGS-1:0] data_hit_o
);
  always_comb sel_o = decode_sel(int'(addr_i), NUM_FLAGS);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_hit
    localparam int unsigned SLOT = REG_DATA0 + i;
    assign data_hit_o[i] = (int'(addr_i) == SLOT);
  end
endmodule

// File: rtl/efr_ctrl_reg.sv
module efr_ctrl_reg #(
  parameter int unsigned NUM_FLAGS = 3,
  parameter int unsigned DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 dma_en_q,
  output logic [NUM_FLAGS-1:0] ie_q,
  output logic                 dma_en_nxt,
  output logic [NUM_FLAGS-1:0] ie_nxt
);
  localparam int unsigned IE_LSB = 1;

  always_comb begin
    dma_en_nxt = dma_en_q;
    ie_nxt     = ie_q;
    if (wr_en_i) begin
      dma_en_nxt = wdata_i[0];
      ie_nxt     = wdata_i[IE_LSB +: NUM_FLAGS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_en_q <= 1'b0;
      ie_q     <= '0;
    end else begin
      dma_en_q <= dma_en_nxt;
      ie_q     <= ie_nxt;
    end
  end
endmodule

// File: rtl/efr_flag_cell.sv
module efr_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_wr_i,
  input  logic clr_rd_i,
  input  logic clr_dma_i,
  output logic flag_q,
  output logic flag_nxt
);
  logic any_clr;

  always_comb begin
    any_clr  = clr_wr_i | clr_rd_i | clr_dma_i;
    flag_nxt = flag_q;
    if (any_clr) flag_nxt = 1'b0;
    if (set_i)   flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_nxt;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_wr_i && !clr_rd_i && !clr_dma_i) |=> flag_q); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (!set_i && (clr_wr_i || clr_rd_i || clr_dma_i)) |=> !flag_q); // R3
endmodule

// File: rtl/efr_read_port.sv
module efr_read_port
  import efr_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 3,
  parameter int unsigned DATA_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_i,
  input  reg_sel_e                    sel_i,
  input  logic [NUM_FLAGS-1:0]        data_hit_i,
  input  logic [NUM_FLAGS-1:0]        flags_i,
  input  logic                        dma_en_i,
  input  logic [NUM_FLAGS-1:0]        ie_i,
  input  logic [NUM_FLAGS*DATA_W-1:0] cap_i,
  output logic [DATA_W-1:0]           rdata_q,
  output logic [NUM_FLAGS-1:0]        rd_clr_o
);
  logic [DATA_W-1:0] data_word;
  logic [DATA_W-1:0] rdata_nxt;

  always_comb begin
    data_word = '0;
    for (int i = 0; i < NUM_FLAGS; i++)
      if (data_hit_i[i]) data_word = cap_i[i*DATA_W +: DATA_W];
  end

  always_comb begin
    rdata_nxt = '0;
    unique case (sel_i)
      SEL_CTRL: begin
        rdata_nxt[0]             = dma_en_i;
        rdata_nxt[1 +: NUM_FLAGS] = ie_i;
      end
      SEL_STATUS: rdata_nxt[NUM_FLAGS-1:0] = flags_i;
      SEL_DATA:   rdata_nxt = data_word;
      default:    rdata_nxt = '0;
    endcase
  end

  assign rd_clr_o = data_hit_i & {NUM_FLAGS{rd_i}};

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_nxt;
  end

  AST_RDCLR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (|rd_clr_o) |-> rd_i); // R5
  AST_RDCLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_clr_o)); // R4
endmodule

// File: rtl/efr_out_stage.sv
module efr_out_stage #(
  parameter int unsigned NUM_FLAGS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] flag_nxt_i,
  input  logic [NUM_FLAGS-1:0] ie_nxt_i,
  input  logic                 dma_en_nxt_i,
  output logic                 irq_q,
  output logic [NUM_FLAGS-1:0] req_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      req_q <= '0;
    end else begin
      irq_q <= !dma_en_nxt_i && (|(flag_nxt_i & ie_nxt_i));
      req_q <= flag_nxt_i & {NUM_FLAGS{dma_en_nxt_i}};
    end
  end
endmodule

// File: rtl/efr_event_flags.sv
module efr_event_flags
  import efr_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 3,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        bus_rd,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_FLAGS-1:0]        evt,
  input  logic [NUM_FLAGS*DATA_W-1:0] cap_data,
  input  logic [NUM_FLAGS-1:0]        dma_done,
  output logic [NUM_FLAGS-1:0]        dma_req,
  output logic                        irq
);
  reg_sel_e             sel;
  logic [NUM_FLAGS-1:0] data_hit;
  logic                 dma_en_q, dma_en_nxt;
  logic [NUM_FLAGS-1:0] ie_q, ie_nxt;
  logic [NUM_FLAGS-1:0] flags_q, flags_nxt;
  logic [NUM_FLAGS-1:0] clr_wr, clr_rd, clr_dma;
  logic                 ctrl_wr;

  efr_addr_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i(bus_addr), .sel_o(sel), .data_hit_o(data_hit));

  assign ctrl_wr = bus_wr && (sel == SEL_CTRL);

  efr_ctrl_reg #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en_i(ctrl_wr), .wdata_i(bus_wdata),
    .dma_en_q(dma_en_q), .ie_q(ie_q), .dma_en_nxt(dma_en_nxt), .ie_nxt(ie_nxt));

  efr_read_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_i(bus_rd), .sel_i(sel), .data_hit_i(data_hit),
    .flags_i(flags_q), .dma_en_i(dma_en_q), .ie_i(ie_q), .cap_i(cap_data),
    .rdata_q(bus_rdata), .rd_clr_o(clr_rd));

  assign clr_wr  = (bus_wr && sel == SEL_STATUS) ? bus_wdata[NUM_FLAGS-1:0] : '0;
  assign clr_dma = dma_done & dma_req & {NUM_FLAGS{dma_en_q}};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    efr_flag_cell u_cell (
      .clk(clk), .rst(rst), .set_i(evt[i]),
      .clr_wr_i(clr_wr[i]), .clr_rd_i(clr_rd[i]), .clr_dma_i(clr_dma[i]),
      .flag_q(flags_q[i]), .flag_nxt(flags_nxt[i]));

    AST_DMA_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (dma_en_q && dma_done[i] && dma_req[i] && !evt[i]) |=> !flags_q[i]); // R6
  end

  efr_out_stage #(.NUM_FLAGS(NUM_FLAGS)) u_out (
    .clk(clk), .rst(rst), .flag_nxt_i(flags_nxt), .ie_nxt_i(ie_nxt),
    .dma_en_nxt_i(dma_en_nxt), .irq_q(irq), .req_q(dma_req));

  AST_REQ_OFF_NO_DMA: assert property (@(posedge clk) disable iff (rst)
    !dma_en_q |-> (dma_req == '0)); // R7
  AST_IRQ_OFF_IN_DMA: assert property (@(posedge clk) disable iff (rst)
    dma_en_q |-> !irq); // R9
  AST_REQ_MIRRORS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    dma_en_q |-> (dma_req == flags_q)); // R10
endmodule

// File: tb/efr_event_flags_test.sv
module efr_event_flags_test;
  localparam int unsigned N  = 3;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0] evt = '0, dma_done = '0, dma_req;
  logic [N*DW-1:0] cap_data = {16'hC3C3, 16'hB2B2, 16'hA1A1};
  logic irq;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  efr_event_flags #(.NUM_FLAGS(N), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .evt(evt), .cap_data(cap_data),
    .dma_done(dma_done), .dma_req(dma_req), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [DW-1:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int unsigned a, output logic [DW-1:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  task automatic clear_all();
    wr(1, 16'h0007);
    wr(0, 16'h0000);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 dma_req", 32'(dma_req), 0);
    rd(1, d); chk("R1 status", 32'(d), 0);
    rd(0, d); chk("R1 ctrl", 32'(d), 0);
  endtask

  task automatic t_set_sticky();
    logic [DW-1:0] d;
    pulse(3'b001); rd(1, d); chk("R2 set", 32'(d), 32'h1);
    pulse(3'b001); rd(1, d); chk("R2 sticky", 32'(d), 32'h1);
    pulse(3'b100); rd(1, d); chk("R2 second flag", 32'(d), 32'h5);
    clear_all();
  endtask

  task automatic t_w1c();
    logic [DW-1:0] d;
    pulse(3'b101);
    wr(1, 16'h0004); rd(1, d); chk("R3 w1c", 32'(d), 32'h1);
    wr(1, 16'h0000); rd(1, d); chk("R3 zero write", 32'(d), 32'h1);
    wr(1, 16'h0001); rd(1, d); chk("R3 last clear", 32'(d), 32'h0);
  endtask

  task automatic t_read_clear();
    logic [DW-1:0] d;
    pulse(3'b111);
    rd(3, d); chk("R11 R4 data1 value", 32'(d), 32'hB2B2);
    rd(1, d); chk("R4 only bound flag", 32'(d), 32'h5);
    rd(0, d); rd(1, d); chk("R4 ctrl/status reads keep", 32'(d), 32'h5);
    rd(4, d); chk("R4 data2 value", 32'(d), 32'hC3C3);
    rd(2, d); chk("R4 data0 value", 32'(d), 32'hA1A1);
    rd(1, d); chk("R4 all cleared", 32'(d), 32'h0);
  endtask

  task automatic t_idle();
    logic [DW-1:0] d;
    pulse(3'b111);
    @(negedge clk); bus_addr = AW'(2);
    repeat (4) @(negedge clk);
    bus_addr = AW'(3);
    repeat (4) @(negedge clk);
    rd(1, d); chk("R5 idle keeps", 32'(d), 32'h7);
    clear_all();
  endtask

  task automatic t_irq();
    logic [DW-1:0] d;
    wr(0, 16'h0004);
    rd(0, d); chk("R9 ctrl readback", 32'(d), 32'h4);
    pulse(3'b001); chk("R9 unmasked flag only", 32'(irq), 0);
    pulse(3'b010); chk("R9 enabled flag", 32'(irq), 1);
    wr(1, 16'h0002); chk("R9 drop on clear", 32'(irq), 0);
    clear_all();
  endtask

  task automatic t_dma_off();
    logic [DW-1:0] d;
    pulse(3'b011);
    @(negedge clk); dma_done = 3'b111;
    @(negedge clk); dma_done = '0;
    chk("R7 no req", 32'(dma_req), 0);
    rd(1, d); chk("R7 done ignored", 32'(d), 32'h3);
    clear_all();
  endtask

  task automatic t_dma_on();
    pulse(3'b011);
    wr(0, 16'h000F);
    chk("R9 irq off in dma", 32'(irq), 0);
    chk("R10 req mirrors", 32'(dma_req), 32'h3);
    repeat (3) @(negedge clk);
    chk("R10 req held", 32'(dma_req), 32'h3);
    @(negedge clk); dma_done = 3'b101;
    @(negedge clk); dma_done = '0;
    chk("R6 done clears", 32'(dma_req), 32'h2);
    wr(0, 16'h0000);
    clear_all();
  endtask

  task automatic t_set_wins();
    logic [DW-1:0] d;
    pulse(3'b001);
    wr(0, 16'h0001);
    @(negedge clk);
    evt = 3'b001; dma_done = 3'b001;
    bus_addr = AW'(1); bus_wdata = 16'h0001; bus_wr = 1'b1;
    @(negedge clk);
    evt = '0; dma_done = '0; bus_wr = 1'b0;
    chk("R8 set over wr/dma", 32'(dma_req), 32'h1);
    @(negedge clk); evt = 3'b001; bus_addr = AW'(2); bus_rd = 1'b1;
    @(negedge clk); evt = '0; bus_rd = 1'b0;
    rd(1, d); chk("R8 set over read", 32'(d), 32'h1);
    wr(0, 16'h0000);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_sticky();
    t_w1c();
    t_read_clear();
    t_idle();
    t_irq();
    t_dma_off();
    t_dma_on();
    t_set_wins();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule